// File: doc/BRIEF.md
# Macroblock Pipeline Stage Sequencer

This controller runs five video-encoding accelerator engines as a skewed macroblock pipeline. The engines, in pipeline order, are an input DMA (index 0), a motion-compensation engine (1), a vector/math unit (2), a deblocking filter (3) and an output DMA (4). The controller works in pipeline steps. In step `t`, engine `k` works on macroblock `t - k`. Steps run from 0 while `t < total + 4`, so the pipeline fills and then drains. Within a step the engines are serviced one after another in pipeline order. The step counter advances only after the output DMA slot has finished.

For an active engine, a slot does three things in order:
1. A one-cycle configure pulse.
2. If the macroblock index is not 0, a wait for the engine's completion of the previous macroblock.
3. A one-cycle start pulse.

For the final macroblock, the slot also waits for that job's own completion before moving on. The motion engine takes part only in P slices. Within a P slice it handles only inter-coded macroblocks. The controller looks up each macroblock's coding type through a combinational query port. After each deblocking start, the controller raises an entropy-encode request.

Top module: `mb_pipe_seq`

## Requirements
- R1: For every engine, start pulses name macroblocks in strictly ascending order starting from 0. Engine k (k ≥ 1) starts macroblock n only after its upstream engine has started n. The upstream engine is k−1, except that the vector unit uses the input DMA.
- R2: Each engine other than the motion engine is configured and then started exactly once per macroblock. `act_mb_o` carries the macroblock index during each configure and start pulse, and no second configure comes before the start.
- R3: An engine is never started while its previous job is still outstanding, meaning its done pulse has not yet been seen. Done pulses may come before the controller reaches its wait, and they are not lost.
- R4: After an engine is started on macroblock `total−1`, no configure or start pulse for any engine appears until that engine's done pulse arrives.
- R5: When `slice_is_p_i` is 0 at frame start, the motion engine (bit 1) receives no configure and no start pulse.
- R6: In a P slice, the motion engine is configured and started only for macroblocks with `inter_i = 1` (1 means inter-coded). `inter_i` is the combinational answer for index `inter_idx_o`. It waits for the previous macroblock only if that macroblock was inter-coded. Macroblock 0 is started with no wait.
- R7: `entropy_req_o` is high for exactly the one cycle after each deblocking start (bit 3), once per macroblock.
- R8: `busy_o` rises the cycle after a `frame_start_i` pulse accepted while idle. It stays high until the last step completes. Then `frame_done_o` pulses for exactly one cycle, with `busy_o` low.
- R9: With a total macroblock count of 0, the frame completes with no configure, start or entropy pulse.
- R10: After reset, `busy_o`, `frame_done_o`, `entropy_req_o` and all configure and start bits are 0.
- R11: At most one configure or start bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Begin a frame (taken when idle) |
| total_mbs_i | input | MB_W | Macroblocks in the frame, latched at start |
| slice_is_p_i | input | 1 | 1 = P slice, latched at start |
| inter_idx_o | output | MB_W | Macroblock index whose coding type is queried |
| inter_i | input | 1 | 1 = queried macroblock is inter-coded |
| eng_done_i | input | 5 | Per-engine completion (bit k = engine k) |
| eng_cfg_o | output | 5 | Per-engine one-cycle configure pulse |
| eng_go_o | output | 5 | Per-engine one-cycle start pulse |
| act_mb_o | output | MB_W | Macroblock index of the current slot |
| entropy_req_o | output | 1 | Entropy-encode request for the latest deblocked macroblock |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with `MB_W = 8`. This keeps the step arithmetic narrow while still allowing frames of up to 20 macroblocks, enough to run the fill, the full five-engine steady state and the drain. Engine stubs answer with a different latency per engine and per frame. As a result, done pulses sometimes arrive before the controller waits and sometimes after it. Frames of 0, 1 and many macroblocks are covered, and so are P slices with mixed, all-intra and intra-first type patterns. These reach the skip, the no-wait first macroblock and the final-wait corners.

// File: rtl/mbp_pkg.sv
// Package: shared constants and the slot state type of the macroblock
// pipeline sequencer. Assumes exactly five engines in fixed pipeline order.
package mbp_pkg;

    localparam int NSTG    = 5;
    localparam int STG_W   = 3;
    localparam int ENG_IN  = 0;
    localparam int ENG_MC  = 1;
    localparam int ENG_VM  = 2;
    localparam int ENG_DB  = 3;
    localparam int ENG_OUT = 4;

    typedef enum logic [2:0] {
        SLT_IDLE = 3'd0,
        SLT_CFG  = 3'd1,
        SLT_WAIT = 3'd2,
        SLT_GO   = 3'd3,
        SLT_LAST = 3'd4
    } slot_state_t;

endpackage

// File: rtl/mbp_done_track.sv
// Module: per-engine pending-completion flags.
// A rising edge on an engine's done input sets its flag.
// The sequencer's consume strobe clears it.
// Assumes one outstanding job per engine, so a set and a clear on the same
// engine never collide.
module mbp_done_track #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] done_i,
    input  logic [N-1:0] consume_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] done_q;

    for (genvar g = 0; g < N; g++) begin : g_eng
        // Capture a rising done edge and hold it until consumed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                done_q[g] <= 1'b0;
                pend_o[g] <= 1'b0;
            end else begin
                done_q[g] <= done_i[g];
                pend_o[g] <= (pend_o[g] & ~consume_i[g]) | (done_i[g] & ~done_q[g]);
            end
        end

        // R3: a completion is consumed only when one is pending.
        a_r3_consume_pending: assert property (@(posedge clk) disable iff (!rst_n)
            consume_i[g] |-> pend_o[g]);
    end

endmodule

// File: rtl/mbp_slot_eval.sv
// Module: combinational slot decision for one (step, engine) pair.
// It derives the engine's macroblock index and whether the engine is active.
// It also decides whether the engine does work, whether it must wait for the
// previous macroblock, and whether this is the final macroblock.
// Assumes step < total + NSTG - 1.
module mbp_slot_eval
    import mbp_pkg::*;
#(
    parameter int MB_W   = 12,
    parameter int STEP_W = MB_W + 1
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [STG_W-1:0]  stage_i,
    input  logic [MB_W-1:0]   total_i,
    input  logic              slice_p_i,
    input  logic              cur_inter_i,
    input  logic              prev_inter_i,
    output logic              active_o,
    output logic              work_o,
    output logic              need_wait_o,
    output logic              last_o,
    output logic [MB_W-1:0]   mb_idx_o
);

    logic [STEP_W-1:0] stage_ext;
    logic [STEP_W-1:0] diff;
    logic [STEP_W-1:0] diff_p1;
    logic              is_mc;
    logic              in_range;

    // Map the step onto this engine's macroblock and qualify the slot.
    always_comb begin
        stage_ext   = STEP_W'(stage_i);
        diff        = step_i - stage_ext;
        diff_p1     = diff + STEP_W'(1);
        is_mc       = (stage_i == STG_W'(ENG_MC));
        in_range    = (step_i >= stage_ext) && (diff < STEP_W'(total_i));
        active_o    = in_range && (!is_mc || slice_p_i);
        work_o      = active_o && (!is_mc || cur_inter_i);
        need_wait_o = active_o && (diff != '0) && (!is_mc || prev_inter_i);
        last_o      = active_o && (diff_p1 == STEP_W'(total_i));
        mb_idx_o    = diff[MB_W-1:0];
    end

endmodule

// File: rtl/mb_pipe_seq.sv
// Module: top of the macroblock pipeline sequencer.
// The slot machine walks the steps and, within each step, the engines in
// pipeline order. Each active slot configures its engine, waits for the
// previous macroblock if needed, starts the engine, and for the final
// macroblock waits for its completion.
// Assumes inter_i answers inter_idx_o combinationally in the same cycle.
// Assumes engine done inputs are pulses or levels whose rising edge marks
// completion.
module mb_pipe_seq
    import mbp_pkg::*;
#(
    parameter int MB_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic [MB_W-1:0]   total_mbs_i,
    input  logic              slice_is_p_i,
    output logic [MB_W-1:0]   inter_idx_o,
    input  logic              inter_i,
    input  logic [NSTG-1:0]   eng_done_i,
    output logic [NSTG-1:0]   eng_cfg_o,
    output logic [NSTG-1:0]   eng_go_o,
    output logic [MB_W-1:0]   act_mb_o,
    output logic              entropy_req_o,
    output logic              busy_o,
    output logic              frame_done_o
);

    localparam int STEP_W = MB_W + 1;

    slot_state_t       state;
    logic [STEP_W-1:0] step;
    logic [STG_W-1:0]  stage;
    logic [MB_W-1:0]   total_q;
    logic              slice_q;
    logic              prev_inter_q;
    logic [STEP_W-1:0] end_step;
    logic [NSTG-1:0]   pend;
    logic [NSTG-1:0]   consume;
    logic              active, work, need_wait, is_last;
    logic              adv;
    logic [STG_W-1:0]  stage_nxt;

    mbp_slot_eval #(.MB_W(MB_W), .STEP_W(STEP_W)) u_eval (
        .step_i      (step),
        .stage_i     (stage),
        .total_i     (total_q),
        .slice_p_i   (slice_q),
        .cur_inter_i (inter_i),
        .prev_inter_i(prev_inter_q),
        .active_o    (active),
        .work_o      (work),
        .need_wait_o (need_wait),
        .last_o      (is_last),
        .mb_idx_o    (act_mb_o)
    );

    mbp_done_track #(.N(NSTG)) u_done (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (eng_done_i),
        .consume_i(consume),
        .pend_o   (pend)
    );

    // Decode per-engine pulses, completion consumption and the slot-advance condition.
    always_comb begin
        end_step    = STEP_W'(total_q) + STEP_W'(NSTG - 1);
        inter_idx_o = step[MB_W-1:0] - MB_W'(1);
        stage_nxt   = stage + STG_W'(1);
        eng_cfg_o   = '0;
        eng_go_o    = '0;
        consume     = '0;
        adv         = 1'b0;
        case (state)
            SLT_CFG: begin
                eng_cfg_o[stage] = work;
                adv              = !active;
            end
            SLT_WAIT: begin
                consume[stage] = need_wait && pend[stage];
            end
            SLT_GO: begin
                eng_go_o[stage] = work;
                adv             = !(work && is_last);
            end
            SLT_LAST: begin
                consume[stage] = pend[stage];
                adv            = pend[stage];
            end
            default: ;
        endcase
    end

    // Slot state machine, step/stage counters and latched frame parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= SLT_IDLE;
            step          <= '0;
            stage         <= '0;
            total_q       <= '0;
            slice_q       <= 1'b0;
            prev_inter_q  <= 1'b0;
            entropy_req_o <= 1'b0;
            frame_done_o  <= 1'b0;
        end else begin
            entropy_req_o <= (state == SLT_GO) && work && (stage == STG_W'(ENG_DB));
            frame_done_o  <= 1'b0;
            if (state == SLT_GO && active && stage == STG_W'(ENG_MC)) begin
                prev_inter_q <= inter_i;
            end
            if (state == SLT_IDLE) begin
                if (frame_start_i) begin
                    total_q      <= total_mbs_i;
                    slice_q      <= slice_is_p_i;
                    prev_inter_q <= 1'b0;
                    step         <= '0;
                    stage        <= '0;
                    state        <= SLT_CFG;
                end
            end else if (adv) begin
                if (stage == STG_W'(NSTG - 1)) begin
                    stage <= '0;
                    if (step + STEP_W'(1) == end_step) begin
                        state        <= SLT_IDLE;
                        frame_done_o <= 1'b1;
                    end else begin
                        step  <= step + STEP_W'(1);
                        state <= SLT_CFG;
                    end
                end else begin
                    stage <= stage_nxt;
                    state <= SLT_CFG;
                end
            end else if (state == SLT_CFG) begin
                state <= SLT_WAIT;
            end else if (state == SLT_WAIT) begin
                if (!need_wait || pend[stage]) state <= SLT_GO;
            end else if (state == SLT_GO) begin
                state <= SLT_LAST;
            end
        end
    end

    assign busy_o = (state != SLT_IDLE);

    // R11: the engine strobes are mutually exclusive.
    a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_cfg_o, eng_go_o}));

    // R8: the end-of-frame pulse comes with the sequencer idle and lasts one cycle.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> !busy_o);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R7: an entropy request always follows a deblocking start.
    a_r7_entropy_after_db: assert property (@(posedge clk) disable iff (!rst_n)
        entropy_req_o |-> $past(eng_go_o[ENG_DB]));

    // R4: while the final job is outstanding, no engine is strobed.
    a_r4_last_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SLT_LAST) |-> (eng_cfg_o == '0 && eng_go_o == '0));

endmodule

// File: tb/mb_pipe_seq_tb.sv
module mb_pipe_seq_tb;

    localparam int MB_W    = 8;
    localparam int CLK_PER = 10;
    localparam int NE      = 5;
    localparam int NVEC    = 6;

    // vector: {total[7:0], slice_p, inter_mask[7:0], lat[1:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {8'd5, 1'b1, 8'b1011_0101, 2'd1},
        {8'd6, 1'b0, 8'hFF,        2'd2},
        {8'd8, 1'b1, 8'hFF,        2'd0},
        {8'd7, 1'b1, 8'h00,        2'd3},
        {8'd1, 1'b1, 8'h01,        2'd1},
        {8'd3, 1'b1, 8'b0000_0110, 2'd2}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_start = 1'b0;
    logic [MB_W-1:0] total_mbs = '0;
    logic            slice_p = 1'b0;
    logic [MB_W-1:0] inter_idx;
    logic            inter_flag;
    logic [NE-1:0]   done_r = '0;
    logic [NE-1:0]   cfg, go;
    logic [MB_W-1:0] act_mb;
    logic            ent_req, busy, fdone;

    int   n_tests = 0, n_fail = 0;
    int   cur_total = 0, cur_lat = 0;
    logic [7:0] cur_mask = '0;
    logic cur_slice = 1'b0;
    bit   running = 0;
    int   cfg_cnt [NE];
    int   go_cnt  [NE];
    int   exp_mb  [NE];
    int   stub_cnt[NE];
    bit   lastw   [NE];
    int   ent_cnt = 0;
    bit   ent_pend = 0;
    int   cyc = 0;

    always #(CLK_PER/2) clk = ~clk;

    assign inter_flag = (inter_idx < 8) ? cur_mask[inter_idx[2:0]] : 1'b1;

    mb_pipe_seq #(.MB_W(MB_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .total_mbs_i(total_mbs), .slice_is_p_i(slice_p),
        .inter_idx_o(inter_idx), .inter_i(inter_flag),
        .eng_done_i(done_r), .eng_cfg_o(cfg), .eng_go_o(go),
        .act_mb_o(act_mb), .entropy_req_o(ent_req),
        .busy_o(busy), .frame_done_o(fdone)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_inter(input int i);
        return (i < 8) ? cur_mask[i] : 1'b1;
    endfunction

    function automatic int next_mc(input int from);
        for (int i = from; i < cur_total; i++) if (is_inter(i)) return i;
        return cur_total;
    endfunction

    // Engine stubs and per-event protocol checks.
    always @(negedge clk) begin
        if (rst_n && running) begin
            if (ent_pend) chk(ent_req == 1'b1, "R7", "entropy after deblock start", ent_req, 1);
            else if (ent_req) chk(0, "R7", "stray entropy request", 1, 0);
            if (ent_req) ent_cnt++;
            ent_pend = 0;
            if (cfg != '0 || go != '0) begin
                chk($countones({cfg, go}) == 1, "R11", "strobes per cycle", $countones({cfg, go}), 1);
                for (int k = 0; k < NE; k++)
                    if (lastw[k]) chk(0, "R4", "strobe during final wait of engine", k, -1);
            end
            for (int k = 0; k < NE; k++)
                if (go[k] && stub_cnt[k] != 0) chk(0, "R3", "start with job outstanding on engine", k, -1);
            for (int k = 0; k < NE; k++) begin
                done_r[k] = 1'b0;
                if (stub_cnt[k] > 0) begin
                    stub_cnt[k]--;
                    if (stub_cnt[k] == 0) begin
                        done_r[k] = 1'b1;
                        lastw[k]  = 0;
                    end
                end
            end
            for (int k = 0; k < NE; k++) begin
                if (cfg[k]) begin
                    if (k == 1) chk(cur_slice, "R5", "motion configured outside P slice", 1, 0);
                    chk(int'(act_mb) == exp_mb[k], (k == 1) ? "R6" : "R2", "configure index", int'(act_mb), exp_mb[k]);
                    chk(cfg_cnt[k] == go_cnt[k], "R2", "configure without start between", cfg_cnt[k], go_cnt[k]);
                    cfg_cnt[k]++;
                end
                if (go[k]) begin
                    chk(cfg_cnt[k] == go_cnt[k] + 1, "R2", "start after configure", cfg_cnt[k], go_cnt[k] + 1);
                    chk(int'(act_mb) == exp_mb[k], (k == 1) ? "R6" : "R1", "start index order", int'(act_mb), exp_mb[k]);
                    if (k > 0) begin
                        int pk;
                        pk = (k == 2) ? 0 : k - 1;
                        chk(go_cnt[pk] > int'(act_mb) || (k == 1 && go_cnt[0] > int'(act_mb)),
                            "R1", "upstream already started", go_cnt[pk], int'(act_mb) + 1);
                    end
                    go_cnt[k]++;
                    exp_mb[k]   = (k == 1) ? next_mc(int'(act_mb) + 1) : int'(act_mb) + 1;
                    stub_cnt[k] = 2 + cur_lat + k;
                    if (int'(act_mb) == cur_total - 1) lastw[k] = 1;
                    if (k == 3) ent_pend = 1;
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still reaches the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <= %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic run_frame(input int tot, input bit sp, input logic [7:0] mask, input int lat);
        int exp_mc;
        int wait_c;
        bit seen;
        cur_total = tot; cur_slice = sp; cur_mask = mask; cur_lat = lat;
        for (int k = 0; k < NE; k++) begin
            cfg_cnt[k] = 0; go_cnt[k] = 0; stub_cnt[k] = 0; lastw[k] = 0;
        end
        exp_mb[0] = 0; exp_mb[2] = 0; exp_mb[3] = 0; exp_mb[4] = 0;
        exp_mb[1] = next_mc(0);
        ent_cnt = 0; ent_pend = 0;
        @(negedge clk);
        total_mbs = MB_W'(tot); slice_p = sp; frame_start = 1'b1; running = 1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        seen = 0;
        wait_c = 0;
        while (!seen && wait_c < 20000) begin
            @(negedge clk);
            wait_c++;
            if (fdone) begin
                seen = 1;
                chk(busy == 1'b0, "R8", "busy low at frame done", busy, 0);
            end else if (!busy) begin
                chk(0, "R8", "busy dropped before frame done", 0, 1);
                seen = 1;
            end
        end
        chk(seen, "R8", "frame done seen", seen, 1);
        @(negedge clk);
        chk(fdone == 1'b0, "R8", "frame done one cycle", fdone, 0);
        repeat (3) @(negedge clk);
        running = 0;
        exp_mc = 0;
        if (sp) for (int i = 0; i < tot; i++) exp_mc += is_inter(i);
        for (int k = 0; k < NE; k++) begin
            int e;
            e = (k == 1) ? exp_mc : tot;
            chk(go_cnt[k] == e, (k == 1) ? (sp ? "R6" : "R5") : ((tot == 0) ? "R9" : "R2"),
                "starts per engine", go_cnt[k], e);
            chk(cfg_cnt[k] == e, (k == 1) ? "R6" : "R2", "configures per engine", cfg_cnt[k], e);
            chk(stub_cnt[k] == 0, "R4", "job outstanding at frame end", stub_cnt[k], 0);
        end
        chk(ent_cnt == tot, (tot == 0) ? "R9" : "R7", "entropy requests", ent_cnt, tot);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0 && fdone == 1'b0 && ent_req == 1'b0, "R10", "status in reset",
            {busy, fdone, ent_req}, 0);
        chk(cfg == '0 && go == '0, "R10", "strobes in reset", {cfg, go}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && cfg == '0 && go == '0, "R10", "idle after reset", {busy, cfg, go}, 0);

        for (int v = 0; v < NVEC; v++)
            run_frame(int'(VEC[v][18:11]), VEC[v][10], VEC[v][9:2], int'(VEC[v][1:0]));

        // R9: empty frame
        run_frame(0, 1'b1, 8'hFF, 0);
        // R1 R3: long frame, slow engines, mixed types
        run_frame(20, 1'b1, 8'b0110_1101, 3);
        // R6: P slice, first macroblock intra, others inter, fast engines
        run_frame(12, 1'b1, 8'b1111_1110, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule